// File: doc/BRIEF.md
# Two-Stage Folded Symmetric FIR Decimator

This block low-pass filters one signed baseband channel and lowers its sample rate by four, in two steps of two. A short symmetric filter runs first and keeps every second result. Its results feed a longer symmetric filter, which again keeps every second result. Each step owns exactly one multiplier. Before the multiply, the two samples that share a coefficient are added, so a filter with N taps (N odd) needs only (N+1)/2 multiply cycles. Both filters use the idle clocks between samples to do this work, one coefficient per clock.

Each filter step is driven by a three-state machine. `S_IDLE` waits for a sample and shifts it into the delay line. A sample that completes a pair of samples takes the transition IDLE→MAC; any other sample stays in IDLE. `S_MAC` adds one folded product per clock and takes MAC→ROUND after the centre tap. `S_ROUND` rounds and saturates the sum into the registered output, raises the strobe, and takes ROUND→IDLE. A sample that arrives while the machine is in MAC or ROUND waits in a one-entry holding register. It is shifted in on the next IDLE cycle.

The coefficients are fixed. Tap k of an N-tap filter has the weight min(k, N−1−k)+1, which gives a triangular, symmetric response. The upstream source gives one sample with a single-cycle valid strobe. The downstream sink takes one filtered sample per output strobe.

Top module: `ddc_fir_decim2x2`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_data` is 0 until the first result. Both delay lines start filled with zeros.
- R2: The first filter has 23 taps with weights h1[k]=min(k,22−k)+1. Counting accepted input samples from 0 after reset, it produces a result only after samples 1, 3, 5, and so on. That result is y1 = Σ h1[k]·x[n−k], taken over every input sample, odd and even.
- R3: Each first-filter sum is rounded as (sum + 64) >>> 7 with an arithmetic shift. It is then clamped to the signed 12-bit range −2048..2047.
- R4: The second filter has 63 taps with weights h2[k]=min(k,62−k)+1 and runs on the first-filter results. Counting those results from 0, it produces an output only after results 1, 3, 5, and so on.
- R5: `out_valid` is a pulse one clock wide. It occurs once for every four accepted input samples.
- R6: `out_data` changes only in a cycle in which `out_valid` is 1. Otherwise it holds its last value.
- R7: Every input sample is accepted and used, even one that arrives while a filter is still accumulating, provided input strobes are at least 10 clocks apart.
- R8: Each second-filter sum is rounded as (sum + 256) >>> 9 with an arithmetic shift. It is then clamped to the signed 12-bit range −2048..2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | Output strobe, at a quarter of the input rate |
| out_data | output | 12 | Signed filtered, decimated sample |

## Verification
The hardest case to reach from the ports is a sample that arrives while a filter is still in MAC or ROUND. That sample must wait in the holding register and be shifted in later, without being lost or reordered. The second filter is the tight one, because its 34-clock busy window is longer than the spacing of its own inputs. The stimulus therefore spends long stretches at the minimum spacing of 10 clocks, mixed with slightly longer random gaps. Full-scale constant inputs of both signs drive both clamps, and an impulse shows the triangular weights directly at the output.

// File: rtl/ddc_fir_pkg.sv
package ddc_fir_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MAC,
        S_ROUND
    } fold_state_t;

    // Triangular symmetric weight for tap k of an ntap-long filter.
    function automatic int tri_coef(input int k, input int ntap);
        int m;
        m = ntap - 1 - k;
        return ((k < m) ? k : m) + 1;
    endfunction

endpackage

// File: rtl/fold_round_sat.sv
module fold_round_sat #(
    parameter int ACC_W = 26,
    parameter int SHIFT = 7,
    parameter int OUT_W = 12
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] res
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (SHIFT - 1);
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] MINV = -EXT_W'(2 ** (OUT_W - 1));

    logic signed [EXT_W-1:0] biased;
    logic signed [EXT_W-1:0] shifted;

    always_comb begin
        biased  = {acc[ACC_W-1], acc} + HALF;
        shifted = biased >>> SHIFT;
        if (shifted > MAXV)
            res = MAXV[OUT_W-1:0];
        else if (shifted < MINV)
            res = MINV[OUT_W-1:0];
        else
            res = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/fir_fold_stage.sv
module fir_fold_stage
    import ddc_fir_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 12,
    parameter int COEF_W = 8,
    parameter int NTAP   = 23,
    parameter int SHIFT  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int NUNIQ  = (NTAP + 1) / 2;
    localparam int CTR    = NUNIQ - 1;
    localparam int IDX_W  = $clog2(NUNIQ);
    localparam int POS_W  = $clog2(NTAP);
    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + IDX_W + 1;

    fold_state_t state, nxt;

    logic signed [IN_W-1:0]   dline [NTAP];
    logic signed [COEF_W-1:0] crom  [NUNIQ];
    logic                     pend_v;
    logic signed [IN_W-1:0]   pend_d;
    logic                     phase;
    logic [IDX_W-1:0]         idx;
    logic signed [ACC_W-1:0]  acc;

    logic                     take;
    logic signed [IN_W-1:0]   take_d;
    logic [POS_W-1:0]         lo_pos, hi_pos;
    logic signed [PRE_W-1:0]  pre;
    logic signed [PROD_W-1:0] prod;
    logic signed [OUT_W-1:0]  rounded;

    // Fixed coefficient table, one entry per folded pair plus centre.
    for (genvar g = 0; g < NUNIQ; g++) begin : g_coef
        assign crom[g] = COEF_W'(tri_coef(g, NTAP));
    end

    assign take   = (state == S_IDLE) && (pend_v || in_valid);
    assign take_d = pend_v ? pend_d : in_data;

    // Folded operand: mirrored samples summed, centre tap alone.
    always_comb begin
        lo_pos = POS_W'(idx);
        hi_pos = POS_W'(NTAP - 1) - lo_pos;
        if (idx == IDX_W'(CTR))
            pre = {dline[lo_pos][IN_W-1], dline[lo_pos]};
        else
            pre = {dline[lo_pos][IN_W-1], dline[lo_pos]}
                + {dline[hi_pos][IN_W-1], dline[hi_pos]};
        prod = pre * crom[idx];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (take && phase)        nxt = S_MAC;
            S_MAC:   if (idx == IDX_W'(CTR))   nxt = S_ROUND;
            S_ROUND:                           nxt = S_IDLE;
            default:                           nxt = S_IDLE;
        endcase
    end

    // Delay line, holding register, decimation phase, accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP; i++) dline[i] <= '0;
            pend_v <= 1'b0;
            pend_d <= '0;
            phase  <= 1'b0;
            idx    <= '0;
            acc    <= '0;
        end else begin
            if (state != S_IDLE) begin
                if (in_valid) begin
                    pend_v <= 1'b1;
                    pend_d <= in_data;
                end
            end else if (pend_v) begin
                pend_v <= 1'b0;
            end
            if (take) begin
                dline[0] <= take_d;
                for (int i = 1; i < NTAP; i++) dline[i] <= dline[i-1];
                phase <= ~phase;
                idx   <= '0;
                acc   <= '0;
            end else if (state == S_MAC) begin
                acc <= acc + ACC_W'(prod);
                idx <= idx + 1'b1;
            end
        end
    end

    fold_round_sat #(
        .ACC_W (ACC_W),
        .SHIFT (SHIFT),
        .OUT_W (OUT_W)
    ) u_rnd (
        .acc (acc),
        .res (rounded)
    );

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == S_ROUND);
            if (state == S_ROUND) out_data <= rounded;
        end
    end

    // R5: strobe lasts one clock
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: data moves only with the strobe
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R7: a second sample never arrives while one is still waiting
    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && pend_v));

    // R2: a sample that opens a pair starts no computation
    p_even_no_mac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !phase) |=> (state == S_IDLE));

endmodule

// File: rtl/ddc_fir_decim2x2.sv
module ddc_fir_decim2x2 #(
    parameter int IN_W   = 12,
    parameter int MID_W  = 12,
    parameter int OUT_W  = 12,
    parameter int COEF_W = 8,
    parameter int TAPS1  = 23,
    parameter int TAPS2  = 63,
    parameter int SHIFT1 = 7,
    parameter int SHIFT2 = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    logic                    mid_valid;
    logic signed [MID_W-1:0] mid_data;

    fir_fold_stage #(
        .IN_W   (IN_W),
        .OUT_W  (MID_W),
        .COEF_W (COEF_W),
        .NTAP   (TAPS1),
        .SHIFT  (SHIFT1)
    ) u_stage1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (mid_valid),
        .out_data  (mid_data)
    );

    fir_fold_stage #(
        .IN_W   (MID_W),
        .OUT_W  (OUT_W),
        .COEF_W (COEF_W),
        .NTAP   (TAPS2),
        .SHIFT  (SHIFT2)
    ) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mid_valid),
        .in_data   (mid_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: tb/sim_ddc_fir_decim2x2.sv
`timescale 1ns/1ps
module sim_ddc_fir_decim2x2;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_data = '0;
    logic              out_valid;
    logic signed [11:0] out_data;

    always #2.5 clk = ~clk;

    ddc_fir_decim2x2 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // golden model state
    longint x1 [23];
    longint x2 [63];
    int     n1 = 0, n2 = 0;
    int     exp_mem [0:1023];
    int     wr = 0, rd = 0;
    int     n_in = 0;

    function automatic longint rsat(longint a, int s);
        longint v;
        v = (a + (64'sd1 <<< (s - 1))) >>> s;
        if (v > 2047)  v = 2047;
        if (v < -2048) v = -2048;
        return v;
    endfunction

    task automatic model_push(input longint x);
        longint acc;
        longint y1;
        for (int i = 22; i > 0; i--) x1[i] = x1[i-1];
        x1[0] = x;
        n1++;
        if ((n1 % 2) == 0) begin
            acc = 0;
            for (int k = 0; k < 23; k++)
                acc += x1[k] * (((k < 22 - k) ? k : 22 - k) + 1);
            y1 = rsat(acc, 7);                           // R3
            for (int i = 62; i > 0; i--) x2[i] = x2[i-1];
            x2[0] = y1;
            n2++;
            if ((n2 % 2) == 0) begin
                acc = 0;
                for (int k = 0; k < 63; k++)
                    acc += x2[k] * (((k < 62 - k) ? k : 62 - k) + 1);
                exp_mem[wr % 1024] = int'(rsat(acc, 9));  // R4, R8
                wr++;
            end
        end
    endtask

    task automatic send(input int v, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 12'(v);
        model_push(longint'(v));
        n_in++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // output monitor
    bit              prev_valid = 0;
    logic signed [11:0] prev_data = '0;
    bit              hold_bad = 0;
    bit              mon_on = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_valid)
                chk(!out_valid, "R5 one-cycle strobe", int'(out_valid), 0);
            if (!out_valid && out_data !== prev_data) hold_bad = 1;
            if (out_valid) begin
                chk(!hold_bad, "R6 hold between strobes", int'(hold_bad), 0);
                hold_bad = 0;
                if (rd < wr)
                    chk(int'(out_data) == exp_mem[rd % 1024],
                        "R2/R4 filtered output", int'(out_data), exp_mem[rd % 1024]);
                else
                    chk(1'b0, "R5 unexpected strobe", rd, wr);
                rd++;
            end
            prev_valid = out_valid;
            prev_data  = out_data;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        int lfsr;
        int g;
        for (int i = 0; i < 23; i++) x1[i] = 0;
        for (int i = 0; i < 63; i++) x2[i] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(out_data == 12'sd0, "R1 data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(out_data == 12'sd0, "R1 data after reset", int'(out_data), 0);
        prev_data = out_data;
        mon_on = 1;

        // impulse then zeros (R2, R4: weights through to output)
        send(2047, 10);
        for (int i = 0; i < 127; i++) send(0, 10);
        // full-scale positive: both clamps engage (R3, R8), minimum spacing (R7)
        for (int i = 0; i < 128; i++) send(2047, 10);
        // full-scale negative
        for (int i = 0; i < 128; i++) send(-2048, 10);
        // alternating signs, odd and even samples both matter (R2)
        for (int i = 0; i < 128; i++) send((i % 2) ? -1500 : 1500, 11);
        // ramp
        for (int i = 0; i < 128; i++) send(i * 30 - 1900, 10);
        // pseudo-random values with gaps 10..13 (R7)
        lfsr = 32'h1ACE;
        for (int i = 0; i < 256; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            g = 10 + (lfsr & 3);
            send((lfsr % 4096) - 2048, g);
        end
        repeat (200) @(negedge clk);

        // R5/R7: one output per four inputs, nothing lost
        chk(rd == n_in / 4, "R5 output count", rd, n_in / 4);
        chk(wr == rd, "R7 all samples consumed", rd, wr);
        done = 1;
        summary();
    end
endmodule